// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

This block is a fixed-length line store placed between two clock domains. A producer pushes pixels or samples in its own clock. A consumer pulls them out in another, unrelated clock. The storage holds `DEPTH` words of `WIDTH` bits, with defaults of 5120 by 8. It behaves as a first-in first-out line buffer.

Each side owns a private address counter. The counter moves only on that side's enabled cycles and is cleared only by that side's synchronous reset. No occupancy flags exist. Both counters wrap from the last word back to word 0. The distance between the write and read positions therefore stays constant, and that distance is set by when each side comes out of reset. This gives a fixed line delay rather than a flow-controlled queue.

The read port has an output enable. When it is off, the data bus is forced to zero and a valid strobe drops. This lets several buffers share a bus without on-chip tri-states.

Top module: `line_delay_mem`

## Requirements
- R1: On a `wr_clk` rising edge with `wr_en` high and `wr_rst` low, `wr_data` is stored at the current write address, and the write address advances by one.
- R2: A write cycle with `wr_en` low stores nothing and leaves the write address unchanged.
- R3: `wr_rst` high at a `wr_clk` edge sets the write address to word 0 and overrides `wr_en`, so no word is stored in that cycle. The next enabled write goes to word 0 and the one after it to word 1.
- R4: `rd_rst` high at a `rd_clk` edge sets the read address to word 0 and clears the read data register to all zeros. The next enabled read returns word 0.
- R5: On a `rd_clk` rising edge with `rd_en` high and `rd_rst` low, the word at the read address appears on `rd_q` after that edge, and the read address advances by one.
- R6: A read cycle with `rd_en` low leaves `rd_q` and the read address unchanged.
- R7: Both address counters step from word `DEPTH-1` to word 0. The enabled cycle numbered `DEPTH+1` after a reset therefore reuses word 0: it overwrites that word on the write side and rereads it on the read side.
- R8: While `rd_oe` is low, `rd_q` is all zeros and `rd_qvalid` is low. While `rd_oe` is high, `rd_qvalid` is high and `rd_q` shows the held read register, with no clock needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write side clock |
| wr_rst | input | 1 | Write side synchronous reset, active high |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | WIDTH | Word to store |
| rd_clk | input | 1 | Read side clock |
| rd_rst | input | 1 | Read side synchronous reset, active high |
| rd_en | input | 1 | Read enable, active high |
| rd_oe | input | 1 | Read output enable, active high |
| rd_q | output | WIDTH | Read data, zero when output is disabled |
| rd_qvalid | output | 1 | High while the read output is driven |

## Verification
The assertions and the bench both assume that a word is never read in the same window in which it is being written. A word stored at write edge n may be read only after at least two more write clock edges. The stimulus respects this in two ways: it completes each batch of writes and then adds several idle write clocks before resetting the read side and reading back. The assertions also assume each reset input is synchronous to its own clock. The bench drives every input on the falling edge of the matching clock, and it runs the two clocks at unrelated periods so that no fixed phase relation is relied on.

// File: rtl/lmem_pkg.sv
`timescale 1ns/1ps
package lmem_pkg;
  localparam int unsigned LM_WIDTH = 8;
  localparam int unsigned LM_DEPTH = 5120;

  // Address width for a given depth, never below one bit.
  function automatic int unsigned lm_aw(input int unsigned depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/lmem_addr_ctr.sv
`timescale 1ns/1ps
module lmem_addr_ctr #(
  parameter int unsigned DEPTH = lmem_pkg::LM_DEPTH,
  localparam int unsigned AW = lmem_pkg::lm_aw(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (en)
      addr_q <= (addr_q == LAST) ? '0 : addr_q + AW'(1);
  end

  assign addr = addr_q;

  // R3 / R4: reset returns the pointer to word 0
  a_r3_r4_ptr_reset: assert property (@(posedge clk) rst |=> addr_q == '0);
  // R2 / R6: disabled cycles freeze the pointer
  a_r2_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(addr_q));
  // R7: last word wraps to zero
  a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && addr_q == LAST) |=> addr_q == '0);
  // R1 / R5: ordinary step
  a_r1_r5_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (en && addr_q != LAST) |=> addr_q == $past(addr_q) + AW'(1));
  // R7: pointer never leaves the array
  a_r7_ptr_range: assert property (@(posedge clk) addr_q <= LAST);
endmodule

// File: rtl/lmem_dp_ram.sv
`timescale 1ns/1ps
module lmem_dp_ram #(
  parameter int unsigned WIDTH = lmem_pkg::LM_WIDTH,
  parameter int unsigned DEPTH = lmem_pkg::LM_DEPTH,
  localparam int unsigned AW = lmem_pkg::lm_aw(DEPTH)
) (
  input  logic             wr_clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_clk,
  input  logic             rclr,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  // Write port: plain synchronous write, suitable for block RAM.
  always_ff @(posedge wr_clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  // Read port: registered output with a synchronous clear.
  always_ff @(posedge rd_clk) begin
    if (rclr)
      rdata_q <= '0;
    else if (re)
      rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

  // R1: the addressed word holds the written value after the edge
  a_r1_word_stored: assert property (@(posedge wr_clk)
    we |=> mem[$past(waddr)] == $past(wdata));
  // R4: clear empties the output register
  a_r4_rdata_clear: assert property (@(posedge rd_clk) rclr |=> rdata_q == '0);
  // R6: no read, no change
  a_r6_rdata_hold: assert property (@(posedge rd_clk) disable iff (rclr)
    !re |=> $stable(rdata_q));
endmodule

// File: rtl/lmem_oe_gate.sv
`timescale 1ns/1ps
module lmem_oe_gate #(
  parameter int unsigned WIDTH = lmem_pkg::LM_WIDTH
) (
  input  logic             oe,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dvalid
);
  // Disabled bus is parked at zero instead of a floating level.
  always_comb begin
    dvalid = oe;
    dout   = oe ? din : '0;
  end
endmodule

// File: rtl/line_delay_mem.sv
`timescale 1ns/1ps
module line_delay_mem #(
  parameter int unsigned WIDTH = lmem_pkg::LM_WIDTH,
  parameter int unsigned DEPTH = lmem_pkg::LM_DEPTH
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic             rd_en,
  input  logic             rd_oe,
  output logic [WIDTH-1:0] rd_q,
  output logic             rd_qvalid
);
  localparam int unsigned AW = lmem_pkg::lm_aw(DEPTH);

  logic [AW-1:0]    wptr;
  logic [AW-1:0]    rptr;
  logic             wr_go;
  logic             rd_go;
  logic [WIDTH-1:0] rd_word;

  // Reset dominates enable on each side.
  assign wr_go = wr_en & ~wr_rst;
  assign rd_go = rd_en & ~rd_rst;

  lmem_addr_ctr #(.DEPTH(DEPTH)) wr_ctr_i (
    .clk (wr_clk),
    .rst (wr_rst),
    .en  (wr_en),
    .addr(wptr)
  );

  lmem_addr_ctr #(.DEPTH(DEPTH)) rd_ctr_i (
    .clk (rd_clk),
    .rst (rd_rst),
    .en  (rd_en),
    .addr(rptr)
  );

  lmem_dp_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) ram_i (
    .wr_clk(wr_clk),
    .we    (wr_go),
    .waddr (wptr),
    .wdata (wr_data),
    .rd_clk(rd_clk),
    .rclr  (rd_rst),
    .re    (rd_go),
    .raddr (rptr),
    .rdata (rd_word)
  );

  lmem_oe_gate #(.WIDTH(WIDTH)) oe_i (
    .oe    (rd_oe),
    .din   (rd_word),
    .dout  (rd_q),
    .dvalid(rd_qvalid)
  );

  // R8: disabled output is parked at zero with the strobe low
  a_r8_oe_parked: assert property (@(posedge rd_clk)
    !rd_oe |-> (!rd_qvalid && rd_q == '0));
  // R8: enabled output forwards the read register
  a_r8_oe_driven: assert property (@(posedge rd_clk)
    rd_oe |-> (rd_qvalid && rd_q == rd_word));
  // R3: no store during a write reset cycle
  a_r3_reset_blocks_write: assert property (@(posedge wr_clk)
    wr_rst |-> !wr_go);
endmodule

// File: tb/line_delay_mem_tb_top.sv
`timescale 1ns/1ps
module line_delay_mem_tb_top;
  localparam int unsigned W = 8;
  localparam int unsigned D = 5120;

  logic         wr_clk = 1'b0;
  logic         rd_clk = 1'b0;
  logic         wr_rst = 1'b1;
  logic         wr_en  = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_rst = 1'b1;
  logic         rd_en  = 1'b0;
  logic         rd_oe  = 1'b1;
  logic [W-1:0] rd_q;
  logic         rd_qvalid;

  always #4    wr_clk = ~wr_clk;   // 125 MHz
  always #5.85 rd_clk = ~rd_clk;   // unrelated read clock

  line_delay_mem #(.WIDTH(W), .DEPTH(D)) dut_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_oe(rd_oe),
    .rd_q(rd_q), .rd_qvalid(rd_qvalid)
  );

  int unsigned  n_chk = 0;
  int unsigned  n_fail = 0;
  bit           done = 0;
  logic [W-1:0] mdl [D];
  int unsigned  wp = 0;
  int unsigned  rp = 0;
  logic [W-1:0] exp_q [$];
  logic [W-1:0] last_exp = '0;
  string        cur_req = "R5";

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] pat(input int unsigned i, input int unsigned seed);
    return W'((i * 37) ^ (i >> 5) ^ (seed * 91));
  endfunction

  // Write driver
  task automatic wr_cycle(input bit en, input logic [W-1:0] d);
    @(negedge wr_clk);
    wr_en = en; wr_data = d;
    @(posedge wr_clk);
    if (en) begin mdl[wp] = d; wp = (wp + 1) % D; end
  endtask

  task automatic wr_idle(input int unsigned n);
    for (int unsigned k = 0; k < n; k++) wr_cycle(1'b0, 8'hEE);
  endtask

  task automatic wr_reset_with_enable();
    @(negedge wr_clk);
    wr_rst = 1'b1; wr_en = 1'b1; wr_data = 8'h5A;  // R3: must not be stored
    @(posedge wr_clk);
    wp = 0;
    @(negedge wr_clk);
    wr_rst = 1'b0; wr_en = 1'b0;
  endtask

  // Read driver: pushes expectations for the monitor
  task automatic rd_read();
    @(negedge rd_clk);
    rd_en = 1'b1;
    exp_q.push_back(mdl[rp]);
    rp = (rp + 1) % D;
  endtask

  task automatic rd_idle_check();
    @(negedge rd_clk);
    rd_en = 1'b0;
    @(negedge rd_clk);
    chk("R6 hold", rd_q, last_exp);
  endtask

  task automatic rd_reset();
    @(negedge rd_clk);
    rd_en = 1'b0; rd_rst = 1'b1;
    @(negedge rd_clk);
    rd_rst = 1'b0;
    rp = 0; last_exp = '0;
    chk("R4 clear", rd_q, '0);
  endtask

  task automatic rd_drain();
    @(negedge rd_clk); rd_en = 1'b0;
    @(negedge rd_clk);
    @(negedge rd_clk);
    chk("R5 drained", W'(exp_q.size()), '0);
  endtask

  // Monitor: compares each enabled read one read edge later
  initial begin
    forever begin
      bit took;
      @(posedge rd_clk);
      took = rd_en && !rd_rst;
      @(negedge rd_clk);
      if (took) begin
        if (exp_q.size() == 0) chk({cur_req, " underflow"}, rd_q, 8'hxx);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(cur_req, rd_q, e);
          last_exp = e;
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int unsigned i = 0; i < D; i++) mdl[i] = '0;
    repeat (3) @(negedge wr_clk);
    repeat (3) @(negedge rd_clk);
    wr_rst = 1'b0;
    rd_rst = 1'b0;
    @(negedge rd_clk);
    chk("R4 reset data", rd_q, '0);
    chk("R8 valid on", W'(rd_qvalid), 8'h01);

    // Full line with interleaved disable cycles (R1, R2)
    for (int unsigned i = 0; i < D; i++) begin
      wr_cycle(1'b1, pat(i, 1));
      if (i % 97 == 5) wr_cycle(1'b0, ~pat(i, 1));
    end
    wr_idle(4);

    cur_req = "R1 R2 R5";
    rd_reset();
    for (int unsigned i = 0; i < D; i++) begin
      rd_read();
      if (i % 700 == 3) rd_idle_check();
    end
    // Read pointer wraps (R7)
    cur_req = "R7 read wrap";
    for (int unsigned i = 0; i < 3; i++) rd_read();
    rd_idle_check();
    rd_drain();

    // Write pointer wrapped: overwrite words 0..2 (R7)
    for (int unsigned i = 0; i < 3; i++) wr_cycle(1'b1, pat(i, 2));
    wr_idle(4);
    cur_req = "R7 write wrap";
    rd_reset();
    for (int unsigned i = 0; i < 5; i++) rd_read();
    rd_drain();

    // Write reset with enable high (R3)
    for (int unsigned i = 0; i < 4; i++) wr_cycle(1'b1, pat(i, 3));
    wr_reset_with_enable();
    wr_cycle(1'b1, 8'hC3);
    wr_cycle(1'b1, 8'h3C);
    wr_idle(4);
    cur_req = "R3 write reset";
    rd_reset();
    for (int unsigned i = 0; i < 8; i++) rd_read();
    rd_drain();

    // Output enable (R8)
    @(negedge rd_clk);
    rd_oe = 1'b0;
    #1;
    chk("R8 parked data", rd_q, '0);
    chk("R8 parked valid", W'(rd_qvalid), '0);
    rd_oe = 1'b1;
    #1;
    chk("R8 restored data", rd_q, last_exp);
    chk("R8 restored valid", W'(rd_qvalid), 8'h01);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule